// File: doc/BRIEF.md
# Polled-Slave CPU Register Interface

This block is the processor-facing side of a serial peripheral that answers a polling master as one of up to 32 slaves. It decodes an 8-bit asynchronous microprocessor bus, with active-low select, write and read strobes and a single address line. Behind that bus it keeps three things: a control word, a byte waiting to be sent, and the last byte received. The control word holds the slave's 5-bit recognition address and a master enable. The line coder and the frame recogniser are separate blocks. They read the address, the enable and the pending transmit byte from this block. They hand received bytes in with a one-cycle load strobe and report a consumed transmit byte with another strobe.

The bus strobes are brought into the clock domain through a configurable synchronizer chain. Every register action happens on the leading (falling) edge of a strobe, not on its level. Two ready flags serve as interrupt requests. The receive flag is set when a byte arrives and clears when the processor starts to read it. The transmit flag shows that the transmit register may be refilled and clears when the processor starts to write it. The reset pin is qualified: a short low glitch is ignored, and only a sustained low returns the block to its idle state. In that state line activity is disabled until software sets the enable.

Top module: `ps_regif`

## Requirements
- R1: A write leading edge with cs_n=0, rd_n=1 and a0=1 loads dev_addr from din[4:0] and comm_en from din[5]; din[7:6] are ignored.
- R2: A write leading edge with cs_n=0, rd_n=1 and a0=0 loads tx_data from din and drops tx_rdy within 3 clocks, while wr_n is still low.
- R3: dout_oe is 1 exactly while cs_n=0 and rd_n=0; with a0=0 dout then shows the receive byte, with a0=1 it shows 0; whenever dout_oe is 0, dout is 0.
- R4: While cs_n=1, strobes on wr_n and rd_n change no register and no flag, and dout_oe stays 0.
- R5: After an accepted reset: comm_en=0, dev_addr=0, tx_data=0, receive byte=0, rx_rdy=0, tx_rdy=1.
- R6: A low on rst_n shorter than RST_MIN_CYC (default 4) consecutive clocks has no effect; a low held for RST_MIN_CYC plus the synchronizer depth, or longer, performs the reset of R5.
- R7: With comm_en=1, an rx_load pulse captures rx_byte and sets rx_rdy; an unread byte is overwritten by the next one and lost.
- R8: A read leading edge with cs_n=0, wr_n=1 and a0=0 clears rx_rdy within 3 clocks, while rd_n is still low.
- R9: With comm_en=1, a tx_taken pulse sets tx_rdy.
- R10: With comm_en=0, rx_load and tx_taken are ignored: the receive byte, rx_rdy and tx_rdy keep their values.
- R11: Only the strobe edge acts: holding wr_n low after a transmit write does not clear tx_rdy again after tx_taken has set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Raw active-low reset, qualified inside |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| a0 | input | 1 | Register select: 1 control, 0 data |
| din | input | 8 | Write data from processor |
| dout | output | 8 | Read data to processor |
| dout_oe | output | 1 | Drive enable for the read data bus |
| rx_load | input | 1 | One-cycle strobe: received byte valid |
| rx_byte | input | 8 | Received byte from the frame block |
| tx_taken | input | 1 | One-cycle strobe: transmit byte consumed |
| dev_addr | output | 5 | Slave recognition address |
| comm_en | output | 1 | Master enable for all line activity |
| tx_data | output | 8 | Byte waiting to be sent |
| rx_rdy | output | 1 | Receive byte waiting (interrupt) |
| tx_rdy | output | 1 | Transmit register free (interrupt) |

## Verification
A wrong access decode shows as a changed dev_addr, comm_en or tx_data three clocks after a strobe falls, so each access is followed by a readback of every exposed register. A flag register that does not act on edges only shows up when a strobe stays low across another event. The bench therefore holds wr_n low while tx_taken fires and watches whether tx_rdy survives. A broken enable gate or reset qualifier is invisible until the next line strobe or reset pulse. For that reason, disabled-state loads and short and long reset lows are each followed at once by a port readback.

// File: rtl/ps_regif_pkg.sv
package ps_regif_pkg;

   typedef enum logic [1:0] {
      ACC_NONE    = 2'd0,
      ACC_CTRL_WR = 2'd1,
      ACC_TX_WR   = 2'd2,
      ACC_RX_RD   = 2'd3
   } acc_e;

   // Classify a bus access from the raw pin levels.
   function automatic acc_e classify(input logic cs_n, input logic wr_n,
                                     input logic rd_n, input logic a0);
      acc_e k;
      k = ACC_NONE;
      if (!cs_n) begin
         if (!wr_n && rd_n)
            k = a0 ? ACC_CTRL_WR : ACC_TX_WR;
         else if (wr_n && !rd_n && !a0)
            k = ACC_RX_RD;
      end
      return k;
   endfunction

endpackage

// File: rtl/ps_rst_qual.sv
module ps_rst_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_LOW     = 4
) (
   input  logic clk,
   input  logic rst_n_raw,
   output logic rst_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("ps_rst_qual: SYNC_STAGES must be at least 2");
   end
   if (MIN_LOW < 2) begin : g_chk_min
      $error("ps_rst_qual: MIN_LOW must be at least 2");
   end

   logic [SYNC_STAGES-1:0] chain;
   logic [MIN_LOW-1:0]     window;
   logic                   rst_q;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_chain
      if (g == 0) begin : g_first
         always_ff @(posedge clk) chain[0] <= rst_n_raw;
      end else begin : g_next
         always_ff @(posedge clk) chain[g] <= chain[g-1];
      end
   end

   always_ff @(posedge clk) begin
      window <= {window[MIN_LOW-2:0], chain[LAST]};
      if (~|window)
         rst_q <= 1'b1;
      else if (chain[LAST])
         rst_q <= 1'b0;
   end

   assign rst_o = rst_q;
endmodule

// File: rtl/ps_sync.sv
module ps_sync #(
   parameter int   WIDTH   = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] fall
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_chk
      $error("ps_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] st [STAGES];
   logic [WIDTH-1:0] prev;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_in
         always_ff @(posedge clk) begin
            if (rst) st[0] <= {WIDTH{RST_VAL}};
            else     st[0] <= d_async;
         end
      end else begin : g_mid
         always_ff @(posedge clk) begin
            if (rst) st[g] <= {WIDTH{RST_VAL}};
            else     st[g] <= st[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) prev <= {WIDTH{RST_VAL}};
      else     prev <= st[LAST];
   end

   assign level = st[LAST];
   assign fall  = prev & ~st[LAST];
endmodule

// File: rtl/ps_flag.sv
module ps_flag #(
   parameter bit   SET_WINS = 1'b1,
   parameter logic RST_VAL  = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic set,
   input  logic clr,
   output logic q
);
   logic nxt;

   if (SET_WINS) begin : g_set_first
      always_comb begin
         if (set)      nxt = 1'b1;
         else if (clr) nxt = 1'b0;
         else          nxt = q;
      end
   end else begin : g_clr_first
      always_comb begin
         if (clr)      nxt = 1'b0;
         else if (set) nxt = 1'b1;
         else          nxt = q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= nxt;
   end
endmodule

// File: rtl/ps_regif.sv
module ps_regif #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2,
   parameter int RST_MIN_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic              a0,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   input  logic              rx_load,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              tx_taken,
   output logic [ADDR_W-1:0] dev_addr,
   output logic              comm_en,
   output logic [DATA_W-1:0] tx_data,
   output logic              rx_rdy,
   output logic              tx_rdy
);
   import ps_regif_pkg::*;

   localparam int EN_BIT  = ADDR_W;
   localparam int SIG_WR  = 0;
   localparam int SIG_RD  = 1;
   localparam int N_STRB  = 2;

   if (DATA_W < ADDR_W + 2) begin : g_chk_w
      $error("ps_regif: DATA_W must leave room for address, enable and spare bits");
   end

   logic              int_rst;
   logic [N_STRB-1:0] strb_lvl;
   logic [N_STRB-1:0] strb_fall;
   acc_e              acc_w;
   acc_e              acc_r;
   logic              ctl_wr_evt;
   logic              tx_wr_evt;
   logic              rx_rd_evt;
   logic [ADDR_W-1:0] addr_q;
   logic              en_q;
   logic [DATA_W-1:0] tx_q;
   logic [DATA_W-1:0] rx_q;
   logic              unused_hi;
   logic              unused_lvl;

   ps_rst_qual #(.SYNC_STAGES(SYNC_STAGES), .MIN_LOW(RST_MIN_CYC)) u_rst (
      .clk       (clk),
      .rst_n_raw (rst_n),
      .rst_o     (int_rst)
   );

   ps_sync #(.WIDTH(N_STRB), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst     (int_rst),
      .d_async ({rd_n, wr_n}),
      .level   (strb_lvl),
      .fall    (strb_fall)
   );

   always_comb begin
      acc_w = ACC_NONE;
      acc_r = ACC_NONE;
      if (strb_fall[SIG_WR]) acc_w = classify(cs_n, 1'b0, rd_n, a0);
      if (strb_fall[SIG_RD]) acc_r = classify(cs_n, wr_n, 1'b0, a0);
   end

   assign ctl_wr_evt = (acc_w == ACC_CTRL_WR);
   assign tx_wr_evt  = (acc_w == ACC_TX_WR);
   assign rx_rd_evt  = (acc_r == ACC_RX_RD);

   always_ff @(posedge clk) begin
      if (int_rst) begin
         addr_q <= '0;
         en_q   <= 1'b0;
         tx_q   <= '0;
         rx_q   <= '0;
      end else begin
         if (ctl_wr_evt) begin
            addr_q <= din[ADDR_W-1:0];
            en_q   <= din[EN_BIT];
         end
         if (tx_wr_evt)
            tx_q <= din;
         if (en_q && rx_load)
            rx_q <= rx_byte;
      end
   end

   ps_flag #(.SET_WINS(1'b1), .RST_VAL(1'b0)) u_rx_flag (
      .clk (clk),
      .rst (int_rst),
      .set (en_q && rx_load),
      .clr (rx_rd_evt),
      .q   (rx_rdy)
   );

   ps_flag #(.SET_WINS(1'b0), .RST_VAL(1'b1)) u_tx_flag (
      .clk (clk),
      .rst (int_rst),
      .set (en_q && tx_taken),
      .clr (tx_wr_evt),
      .q   (tx_rdy)
   );

   assign dout_oe = !cs_n && !rd_n;
   assign dout    = (dout_oe && !a0) ? rx_q : '0;

   assign dev_addr = addr_q;
   assign comm_en  = en_q;
   assign tx_data  = tx_q;

   assign unused_hi  = ^din[DATA_W-1:EN_BIT+1];
   assign unused_lvl = ^strb_lvl;
endmodule

// File: rtl/ps_regif_chk.sv
module ps_regif_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              int_rst,
   input logic              comm_en,
   input logic              rx_load,
   input logic [DATA_W-1:0] rx_byte,
   input logic [DATA_W-1:0] rx_q,
   input logic              rx_rdy,
   input logic              tx_rdy,
   input logic              tx_wr_evt,
   input logic              rx_rd_evt,
   input logic              tx_taken,
   input logic [DATA_W-1:0] dout,
   input logic              dout_oe
);
   // R5
   rst_idle_chk: assert property (@(posedge clk)
      int_rst |=> (!comm_en && !rx_rdy && tx_rdy));

   // R3
   bus_quiet_chk: assert property (@(posedge clk) disable iff (int_rst)
      !dout_oe |-> (dout == '0));

   // R7
   rx_capture_chk: assert property (@(posedge clk) disable iff (int_rst)
      (comm_en && rx_load) |=> (rx_rdy && rx_q == $past(rx_byte)));

   // R10
   rx_gate_chk: assert property (@(posedge clk) disable iff (int_rst)
      (!comm_en && rx_load) |=> $stable(rx_q));

   // R2
   tx_clear_chk: assert property (@(posedge clk) disable iff (int_rst)
      tx_wr_evt |=> !tx_rdy);

   // R8
   rx_clear_chk: assert property (@(posedge clk) disable iff (int_rst)
      (rx_rd_evt && !(comm_en && rx_load)) |=> !rx_rdy);

   // R9
   tx_set_chk: assert property (@(posedge clk) disable iff (int_rst)
      (comm_en && tx_taken && !tx_wr_evt) |=> tx_rdy);
endmodule

bind ps_regif ps_regif_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .int_rst   (int_rst),
   .comm_en   (comm_en),
   .rx_load   (rx_load),
   .rx_byte   (rx_byte),
   .rx_q      (rx_q),
   .rx_rdy    (rx_rdy),
   .tx_rdy    (tx_rdy),
   .tx_wr_evt (tx_wr_evt),
   .rx_rd_evt (rx_rd_evt),
   .tx_taken  (tx_taken),
   .dout      (dout),
   .dout_oe   (dout_oe)
);

// File: tb/ps_regif_test.sv
module ps_regif_test;
   localparam int CLK_PERIOD = 250;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a0 = 1'b0;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       dout_oe;
   logic       rx_load = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       tx_taken = 1'b0;
   logic [4:0] dev_addr;
   logic       comm_en;
   logic [7:0] tx_data;
   logic       rx_rdy, tx_rdy;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      int         sel;
      logic [7:0] exp;
      string      tag;
   } item_t;
   item_t sb[$];

   localparam int S_DOUT = 0, S_OE = 1, S_RXRDY = 2, S_TXRDY = 3,
                  S_EN = 4, S_ADDR = 5, S_TXD = 6;

   always #(CLK_PERIOD/2) clk = ~clk;

   ps_regif uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .a0(a0), .din(din), .dout(dout), .dout_oe(dout_oe),
      .rx_load(rx_load), .rx_byte(rx_byte), .tx_taken(tx_taken),
      .dev_addr(dev_addr), .comm_en(comm_en), .tx_data(tx_data),
      .rx_rdy(rx_rdy), .tx_rdy(tx_rdy)
   );

   function automatic logic [7:0] observe(int sel);
      case (sel)
         S_DOUT:  return dout;
         S_OE:    return {7'd0, dout_oe};
         S_RXRDY: return {7'd0, rx_rdy};
         S_TXRDY: return {7'd0, tx_rdy};
         S_EN:    return {7'd0, comm_en};
         S_ADDR:  return {3'd0, dev_addr};
         default: return tx_data;
      endcase
   endfunction

   // monitor: pops expected items a quarter period after each rising edge
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      while (sb.size() > 0) begin
         item_t it;
         logic [7:0] act;
         it  = sb.pop_front();
         act = observe(it.sel);
         n_tests++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: sel %0d actual %h expected %h", it.tag, it.sel, act, it.exp);
         end
      end
   end

   task automatic expect_v(int sel, logic [7:0] e, string tag);
      item_t it;
      it.sel = sel; it.exp = e; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic flush();
      @(posedge clk);
      #(CLK_PERIOD/2);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(logic sel, logic [7:0] d, logic sel_chip);
      @(negedge clk); cs_n = ~sel_chip; a0 = sel; din = d;
      @(negedge clk); wr_n = 1'b0;
      idle(5);
      wr_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
      idle(3);
   endtask

   task automatic line_rx(logic [7:0] b);
      @(negedge clk); rx_load = 1'b1; rx_byte = b;
      @(negedge clk); rx_load = 1'b0;
      idle(1);
   endtask

   task automatic line_tx_taken();
      @(negedge clk); tx_taken = 1'b1;
      @(negedge clk); tx_taken = 1'b0;
      idle(1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      idle(12);
      rst_n = 1'b1;
      idle(4);
      // R5 reset state
      expect_v(S_EN, 8'h00, "R5"); expect_v(S_ADDR, 8'h00, "R5");
      expect_v(S_RXRDY, 8'h00, "R5"); expect_v(S_TXRDY, 8'h01, "R5");
      expect_v(S_TXD, 8'h00, "R5"); expect_v(S_OE, 8'h00, "R5");
      flush();

      // R2 transmit write while disabled, R10 gating
      bus_write(1'b0, 8'h3C, 1'b1);
      expect_v(S_TXD, 8'h3C, "R2"); expect_v(S_TXRDY, 8'h00, "R2");
      flush();
      line_rx(8'hA5);
      line_tx_taken();
      expect_v(S_RXRDY, 8'h00, "R10"); expect_v(S_TXRDY, 8'h00, "R10");
      flush();
      @(negedge clk); cs_n = 1'b0; a0 = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      expect_v(S_DOUT, 8'h00, "R10"); expect_v(S_OE, 8'h01, "R3");
      flush();
      idle(4); rd_n = 1'b1; cs_n = 1'b1; idle(3);

      // R1 control writes, spare bits ignored
      bus_write(1'b1, 8'hF3, 1'b1);
      expect_v(S_ADDR, 8'h13, "R1"); expect_v(S_EN, 8'h01, "R1");
      flush();
      bus_write(1'b1, 8'hC0, 1'b1);
      expect_v(S_ADDR, 8'h00, "R1"); expect_v(S_EN, 8'h00, "R1");
      flush();
      bus_write(1'b1, 8'h2A, 1'b1);
      expect_v(S_ADDR, 8'h0A, "R1"); expect_v(S_EN, 8'h01, "R1");
      expect_v(S_TXD, 8'h3C, "R1");
      flush();

      // R4 chip not selected
      bus_write(1'b0, 8'hFF, 1'b0);
      bus_write(1'b1, 8'h00, 1'b0);
      expect_v(S_TXD, 8'h3C, "R4"); expect_v(S_TXRDY, 8'h00, "R4");
      expect_v(S_EN, 8'h01, "R4"); expect_v(S_ADDR, 8'h0A, "R4");
      flush();
      @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; a0 = 1'b0;
      @(negedge clk);
      expect_v(S_OE, 8'h00, "R4"); expect_v(S_DOUT, 8'h00, "R4");
      flush();
      rd_n = 1'b1; idle(3);

      // R9 transmit consumed
      line_tx_taken();
      expect_v(S_TXRDY, 8'h01, "R9");
      flush();

      // R2 leading edge clear, R11 edge only
      @(negedge clk); cs_n = 1'b0; a0 = 1'b0; din = 8'h81;
      @(negedge clk); wr_n = 1'b0;
      idle(4);
      expect_v(S_TXRDY, 8'h00, "R2"); expect_v(S_TXD, 8'h81, "R2");
      flush();
      line_tx_taken();
      idle(3);
      expect_v(S_TXRDY, 8'h01, "R11");
      flush();
      wr_n = 1'b1; @(negedge clk); cs_n = 1'b1; idle(3);
      expect_v(S_TXRDY, 8'h01, "R11"); expect_v(S_TXD, 8'h81, "R11");
      flush();

      // R7 receive, R3 read data, R8 clear on leading edge
      line_rx(8'h5A);
      expect_v(S_RXRDY, 8'h01, "R7");
      flush();
      @(negedge clk); cs_n = 1'b0; a0 = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      expect_v(S_OE, 8'h01, "R3"); expect_v(S_DOUT, 8'h5A, "R3");
      flush();
      idle(3);
      expect_v(S_RXRDY, 8'h00, "R8"); expect_v(S_DOUT, 8'h5A, "R8");
      flush();
      rd_n = 1'b1; @(negedge clk);
      expect_v(S_OE, 8'h00, "R3");
      flush();
      a0 = 1'b1; rd_n = 1'b0; @(negedge clk);
      expect_v(S_OE, 8'h01, "R3"); expect_v(S_DOUT, 8'h00, "R3");
      flush();
      rd_n = 1'b1; cs_n = 1'b1; a0 = 1'b0; idle(3);

      // R7 overwrite of unread byte
      line_rx(8'h11);
      line_rx(8'h22);
      @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      expect_v(S_DOUT, 8'h22, "R7"); expect_v(S_RXRDY, 8'h01, "R7");
      flush();
      rd_n = 1'b1; cs_n = 1'b1; idle(3);

      // R6 short reset glitch ignored
      @(negedge clk); rst_n = 1'b0;
      idle(2); rst_n = 1'b1;
      idle(8);
      expect_v(S_EN, 8'h01, "R6"); expect_v(S_ADDR, 8'h0A, "R6");
      expect_v(S_TXD, 8'h81, "R6");
      flush();

      // R6 long reset accepted
      @(negedge clk); rst_n = 1'b0;
      idle(10); rst_n = 1'b1;
      idle(6);
      expect_v(S_EN, 8'h00, "R6"); expect_v(S_ADDR, 8'h00, "R6");
      expect_v(S_TXRDY, 8'h01, "R6"); expect_v(S_TXD, 8'h00, "R6");
      expect_v(S_RXRDY, 8'h00, "R5");
      flush();

      idle(2);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule